// File: doc/BRIEF.md
# Multi-Hit Windowed TDC Collector

This block collects hit times from a bank of single-bit hit lines (32 by default). A trigger starts an event. A fixed number of clock ticks later, a matching window opens. It stays open for a fixed number of ticks. While the window is open, each rising edge on a hit line is a candidate hit. Its time is stored as the tick offset from the first open cycle.

Each channel keeps up to a set number of hits. A channel accepts a later hit only when that hit is more than a set dead time after the channel's last accepted hit. This models the conversion time of a real converter. Hits before the window opens or after it closes are thrown away.

When the window closes, the block streams one packet as 16-bit halves on a valid/word output, with no gaps. The packet holds an opening tag, a header carrying the hit count, one data word per accepted hit, an ender carrying an event number, and a closing tag. Each 32-bit word goes out low half first.

Top module: `tdc_multihit_collector`

## Requirements
- R1: While reset is asserted, and until a trigger's window has closed after reset release, `out_valid_o` stays 0. A reset in the middle of an event discards that event and sets the event number back to 0.
- R2: A packet is sent on consecutive cycles with `out_valid_o` high. It is 0x0DDC, then header low and high, then the low and high halves of each data word, then ender low and high, then 0xFDDC. Every 32-bit word goes out low half first.
- R3: Header bits [15:0] hold the number of data words in the packet. Bits [31:30] are 2'b01 and all other bits are 0, so the high half is 0x4000.
- R4: Data word bits [15:0] hold the hit time, in ticks from the first open cycle of the window (offset 0). Bits [20:16] hold the channel number. Bits [31:30] are 2'b00 and all other bits are 0.
- R5: The window opens WIN_DELAY cycles after the cycle in which the trigger is taken and stays open for WIN_WIDTH cycles (offsets 0 to WIN_WIDTH-1). Hits at negative offsets or at offsets of WIN_WIDTH and above are not recorded.
- R6: A hit on a channel that already holds a hit is kept only if its offset minus the offset of that channel's last kept hit is greater than DEAD_TICKS. A dropped hit does not restart the dead time.
- R7: A channel keeps at most MAX_HITS hits per event. Further hits are dropped.
- R8: Data words are ordered by channel number, lowest first, and within one channel by time, earliest first.
- R9: Ender bits [13:0] hold the number of packets sent since reset, modulo 2^14, so the first packet carries 0. Bits [31:30] are 2'b11 and all other bits are 0, so the high half is 0xC000.
- R10: A trigger that arrives during the delay, the open window or the readout is ignored. It neither restarts timing nor causes a second packet.
- R11: The opening tag appears in the cycle right after the last open cycle. An event with no accepted hits gives a 6-half packet with a header count of 0.
- R12: A hit is a 0-to-1 transition of a hit line. A line held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick of the time base |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Trigger; taken only while the block is idle |
| hit_i | input | N_CH | Hit lines, one per channel |
| out_valid_o | output | 1 | High while a packet half is on `out_word_o` |
| out_word_o | output | 16 | Packet half |

## Verification
The table-driven events separate the single-hit and multi-hit cases on a mix of channels. They place hits exactly on both edges of the dead time, to show the strict comparison, and put a dropped hit between two kept ones, to show the dead time is timed from the last kept hit. Other events place hits one tick before and after each window edge, overflow one channel past its hit limit, and fire hits on several channels in the same tick in reverse channel order, so that channel-then-time ordering differs from arrival order. Extra triggers during the delay, the window and the readout, a hit line held high across several hit times, an empty event and a reset partway through an event make up the rest. Each one tells apart a timing, filtering or framing rule that the plain cases leave untested.

// File: rtl/tdc_collect_pkg.sv
package tdc_collect_pkg;

  localparam int TIME_W = 16;
  localparam int EVT_W  = 14;

  localparam logic [15:0] TAG_OPEN  = 16'h0DDC;
  localparam logic [15:0] TAG_CLOSE = 16'hFDDC;

  localparam logic [1:0] KIND_DATA = 2'b00;
  localparam logic [1:0] KIND_HDR  = 2'b01;
  localparam logic [1:0] KIND_END  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DELAY,
    PH_OPEN,
    PH_READ
  } phase_t;

  typedef enum logic [3:0] {
    PK_IDLE,
    PK_TAG,
    PK_HLO,
    PK_HHI,
    PK_DLO,
    PK_DHI,
    PK_ELO,
    PK_EHI,
    PK_ETAG
  } pk_state_t;

endpackage

// File: rtl/tdc_window_timer.sv
module tdc_window_timer
  import tdc_collect_pkg::*;
#(
  parameter int WIN_DELAY = 254,
  parameter int WIN_WIDTH = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              done_i,
  output phase_t            phase_o,
  output logic              open_o,
  output logic              arm_o,
  output logic              close_o,
  output logic [TIME_W-1:0] rel_o
);

  localparam int SPAN  = (WIN_DELAY > WIN_WIDTH) ? WIN_DELAY : WIN_WIDTH;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(WIN_DELAY - 1);
  localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(WIN_WIDTH - 1);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (trig_i) begin
          ph_d   = PH_DELAY;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      PH_DELAY: begin
        cnt_en = 1'b1;
        if (cnt_q == DLY_LAST) begin
          ph_d  = PH_OPEN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_OPEN: begin
        if (cnt_q == WID_LAST) begin
          ph_d = PH_READ;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      PH_READ: begin
        if (done_i) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign open_o  = (ph_q == PH_OPEN);
  assign arm_o   = (ph_q == PH_IDLE) && trig_i;
  assign close_o = (ph_q == PH_OPEN) && (cnt_q == WID_LAST);
  assign rel_o   = TIME_W'(cnt_q);

endmodule

// File: rtl/tdc_hit_lane.sv
module tdc_hit_lane
  import tdc_collect_pkg::*;
#(
  parameter int MAX_HITS   = 4,
  parameter int DEAD_TICKS = 40,
  localparam int CW = $clog2(MAX_HITS + 1),
  localparam int IW = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             hit_i,
  input  logic                             open_i,
  input  logic                             clear_i,
  input  logic [TIME_W-1:0]                rel_i,
  output logic [CW-1:0]                    cnt_o,
  output logic [MAX_HITS-1:0][TIME_W-1:0]  times_o
);

  localparam logic [CW-1:0]     CNT_FULL = CW'(MAX_HITS);
  localparam logic [TIME_W-1:0] DEAD_LIM = TIME_W'(DEAD_TICKS);

  logic                            hit_q;
  logic [CW-1:0]                   cnt_q, cnt_d;
  logic                            cnt_en;
  logic [MAX_HITS-1:0][TIME_W-1:0] times_q;
  logic                            rise, gap_ok, take;
  logic [TIME_W-1:0]               last_t;
  logic [IW-1:0]                   wr_idx, last_idx;

  assign rise     = hit_i & ~hit_q;
  assign wr_idx   = IW'(cnt_q);
  assign last_idx = IW'(cnt_q - 1'b1);
  assign last_t   = times_q[last_idx];
  assign gap_ok   = (cnt_q == '0) || ((rel_i - last_t) > DEAD_LIM);
  assign take     = rise && open_i && (cnt_q != CNT_FULL) && gap_ok;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (take) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      cnt_q   <= '0;
      times_q <= '0;
    end else begin
      hit_q <= hit_i;
      if (cnt_en) cnt_q <= cnt_d;
      if (take) times_q[wr_idx] <= rel_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign times_o = times_q;

endmodule

// File: rtl/tdc_packet_builder.sv
module tdc_packet_builder
  import tdc_collect_pkg::*;
#(
  parameter int N_CH     = 32,
  parameter int MAX_HITS = 4,
  localparam int CW  = $clog2(MAX_HITS + 1),
  localparam int IW  = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SW  = $clog2(N_CH * MAX_HITS + 1)
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       start_i,
  input  logic [N_CH-1:0][CW-1:0]                    cnt_i,
  input  logic [N_CH-1:0][MAX_HITS-1:0][TIME_W-1:0]  times_i,
  output logic                                       valid_o,
  output logic [15:0]                                word_o,
  output logic                                       done_o
);

  function automatic logic [CHW-1:0] lowest_set(input logic [N_CH-1:0] m);
    lowest_set = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (m[i]) lowest_set = CHW'(i);
    end
  endfunction

  pk_state_t       st_q, st_d;
  logic [N_CH-1:0] pend_q, pend_d, busy_ch, pend_left;
  logic [CHW-1:0]  ch_q, ch_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [SW-1:0]   total;
  logic            more_in_ch;

  always_comb begin
    total = '0;
    for (int i = 0; i < N_CH; i++) begin
      total     = total + SW'(cnt_i[i]);
      busy_ch[i] = (cnt_i[i] != '0);
    end
  end

  assign more_in_ch = (CW'(idx_q) + 1'b1) < cnt_i[ch_q];
  assign pend_left  = pend_q & ~(N_CH'(1) << ch_q);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    ch_d   = ch_q;
    idx_d  = idx_q;
    evt_d  = evt_q;
    case (st_q)
      PK_IDLE: if (start_i) st_d = PK_TAG;
      PK_TAG: begin
        pend_d = busy_ch;
        st_d   = PK_HLO;
      end
      PK_HLO: st_d = PK_HHI;
      PK_HHI: begin
        if (pend_q == '0) begin
          st_d = PK_ELO;
        end else begin
          ch_d  = lowest_set(pend_q);
          idx_d = '0;
          st_d  = PK_DLO;
        end
      end
      PK_DLO: st_d = PK_DHI;
      PK_DHI: begin
        if (more_in_ch) begin
          idx_d = idx_q + 1'b1;
          st_d  = PK_DLO;
        end else begin
          pend_d = pend_left;
          if (pend_left == '0) begin
            st_d = PK_ELO;
          end else begin
            ch_d  = lowest_set(pend_left);
            idx_d = '0;
            st_d  = PK_DLO;
          end
        end
      end
      PK_ELO: st_d = PK_EHI;
      PK_EHI: st_d = PK_ETAG;
      PK_ETAG: begin
        evt_d = evt_q + 1'b1;
        st_d  = PK_IDLE;
      end
      default: st_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PK_IDLE;
      pend_q <= '0;
      ch_q   <= '0;
      idx_q  <= '0;
      evt_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ch_q   <= ch_d;
      idx_q  <= idx_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    case (st_q)
      PK_TAG:  word_o = TAG_OPEN;
      PK_HLO:  word_o = 16'(total);
      PK_HHI:  word_o = {KIND_HDR, 14'b0};
      PK_DLO:  word_o = times_i[ch_q][idx_q];
      PK_DHI:  word_o = {KIND_DATA, 14'(ch_q)};
      PK_ELO:  word_o = 16'(evt_q);
      PK_EHI:  word_o = {KIND_END, 14'b0};
      PK_ETAG: word_o = TAG_CLOSE;
      default: word_o = '0;
    endcase
  end

  assign valid_o = (st_q != PK_IDLE);
  assign done_o  = (st_q == PK_ETAG);

endmodule

// File: rtl/tdc_multihit_collector.sv
module tdc_multihit_collector
  import tdc_collect_pkg::*;
#(
  parameter int N_CH       = 32,
  parameter int MAX_HITS   = 4,
  parameter int WIN_DELAY  = 254,
  parameter int WIN_WIDTH  = 160,
  parameter int DEAD_TICKS = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [N_CH-1:0] hit_i,
  output logic            out_valid_o,
  output logic [15:0]     out_word_o
);

  localparam int CW = $clog2(MAX_HITS + 1);

  logic [1:0]                             rst_sync_q;
  logic                                   rst_q;
  phase_t                                 phase;
  logic                                   win_open, win_arm, win_close, pk_done;
  logic [TIME_W-1:0]                      rel_t;
  logic [N_CH-1:0][CW-1:0]                lane_cnt;
  logic [N_CH-1:0][MAX_HITS-1:0][TIME_W-1:0] lane_times;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  tdc_window_timer #(
    .WIN_DELAY (WIN_DELAY),
    .WIN_WIDTH (WIN_WIDTH)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .trig_i  (trig_i),
    .done_i  (pk_done),
    .phase_o (phase),
    .open_o  (win_open),
    .arm_o   (win_arm),
    .close_o (win_close),
    .rel_o   (rel_t)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    tdc_hit_lane #(
      .MAX_HITS   (MAX_HITS),
      .DEAD_TICKS (DEAD_TICKS)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_q),
      .hit_i   (hit_i[c]),
      .open_i  (win_open),
      .clear_i (win_arm),
      .rel_i   (rel_t),
      .cnt_o   (lane_cnt[c]),
      .times_o (lane_times[c])
    );
  end

  tdc_packet_builder #(
    .N_CH     (N_CH),
    .MAX_HITS (MAX_HITS)
  ) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .start_i (win_close),
    .cnt_i   (lane_cnt),
    .times_i (lane_times),
    .valid_o (out_valid_o),
    .word_o  (out_word_o),
    .done_o  (pk_done)
  );

endmodule

// File: rtl/tdc_collector_checker.sv
module tdc_collector_checker
  import tdc_collect_pkg::*;
#(
  parameter int N_CH     = 32,
  parameter int CW       = 3,
  parameter int MAX_HITS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid,
  input logic [15:0]             word,
  input phase_t                  phase,
  input logic                    close,
  input logic [N_CH-1:0][CW-1:0] cnts
);

  // R2: every packet begins with the opening tag
  a_r2_opens_with_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (word == TAG_OPEN));

  // R2: the closing tag is the final half of a packet
  a_r2_closes_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && word == TAG_CLOSE) |=> !valid);

  // R11: the packet starts right after the last open cycle
  a_r11_close_starts_packet: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (valid && word == TAG_OPEN));

  // R11: output only during the readout phase of the timer
  a_r11_out_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (phase == PH_READ));

  // R5: hit storage does not change once the window is closed
  a_r5_frozen_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |=> $stable(cnts));

  // R10: a running delay or window is never cut back to idle
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DELAY || phase == PH_OPEN) |=> (phase != PH_IDLE));

  for (genvar c = 0; c < N_CH; c++) begin : g_cap
    // R7: no channel holds more than MAX_HITS hits
    a_r7_lane_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnts[c] <= CW'(MAX_HITS));
  end

endmodule

bind tdc_multihit_collector tdc_collector_checker #(
  .N_CH     (N_CH),
  .CW       (CW),
  .MAX_HITS (MAX_HITS)
) u_checker (
  .clk   (clk_i),
  .rst_n (rst_q),
  .valid (out_valid_o),
  .word  (out_word_o),
  .phase (phase),
  .close (win_close),
  .cnts  (lane_cnt)
);

// File: tb/test_tdc_multihit_collector.sv
`timescale 1ns/1ps
module test_tdc_multihit_collector;

  localparam int N_CH = 32;
  localparam int MAXH = 4;
  localparam int DLY  = 40;
  localparam int WID  = 120;
  localparam int DEAD = 20;
  localparam int NEV  = 7;
  localparam int NROW = 33;
  localparam int TRIG_CH = 32;

  // rows: event, channel (32 = extra trigger), offset from window opening, pulse length
  localparam int ROWS [NROW][4] = '{
    '{1, 0, 0, 1}, '{1, 7, 20, 1}, '{1, 11, 30, 1}, '{1, 0, 60, 1}, '{1, 0, 121, 1},
    // R6 dead-time edges
    '{2, 3, 10, 1}, '{2, 3, 30, 1}, '{2, 3, 32, 1}, '{2, 5, 0, 1}, '{2, 5, 21, 1},
    '{2, 6, 50, 1}, '{2, 6, 70, 1},
    // R5 window edges
    '{3, 2, -5, 1}, '{3, 2, 3, 1}, '{3, 31, 119, 1}, '{3, 30, 120, 1}, '{3, 29, -1, 1},
    // R7 hit limit
    '{4, 9, 0, 1}, '{4, 9, 21, 1}, '{4, 9, 42, 1}, '{4, 9, 63, 1}, '{4, 9, 84, 1},
    '{4, 9, 105, 1},
    // R8 ordering and R10 triggers while busy
    '{5, 20, 5, 1}, '{5, 1, 5, 1}, '{5, 15, 8, 1}, '{5, 1, 40, 1},
    '{5, 32, -20, 1}, '{5, 32, 50, 1}, '{5, 32, 122, 1},
    // R12 held lines
    '{6, 4, 2, 30}, '{6, 4, 40, 1}, '{6, 8, 100, 40}
  };
  localparam string EV_REQ [NEV] = '{"R11", "R2", "R6", "R5", "R7", "R10", "R12"};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trig;
  logic [N_CH-1:0] hit;
  logic            ov;
  logic [15:0]     ow;

  always #2 clk = ~clk;

  tdc_multihit_collector #(
    .N_CH       (N_CH),
    .MAX_HITS   (MAXH),
    .WIN_DELAY  (DLY),
    .WIN_WIDTH  (WID),
    .DEAD_TICKS (DEAD)
  ) i_tdc_multihit_collector (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .trig_i      (trig),
    .hit_i       (hit),
    .out_valid_o (ov),
    .out_word_o  (ow)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] cap    [0:1023];
  int          capcyc [0:1023];
  int          cap_n = 0;
  always @(negedge clk) begin
    if (ov && cap_n < 1024) begin
      cap[cap_n]    = ow;
      capcyc[cap_n] = cyc;
      cap_n         = cap_n + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int evt_exp = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_event(input int ev);
    int acc [N_CH][MAXH];
    int na [N_CH];
    int expw [0:299];
    int n_exp, base, e0, len, r;
    logic trig_v;
    logic [N_CH-1:0] hv;
    string req;
    for (int c = 0; c < N_CH; c++) na[c] = 0;
    for (int i = 0; i < NROW; i++) begin
      if (ROWS[i][0] == ev && ROWS[i][1] < N_CH) begin
        int c, t;
        c = ROWS[i][1];
        t = ROWS[i][2];
        if (t >= 0 && t < WID && na[c] < MAXH && (na[c] == 0 || t - acc[c][na[c]-1] > DEAD)) begin
          acc[c][na[c]] = t;
          na[c]++;
        end
      end
    end
    n_exp = 0;
    expw[n_exp++] = 16'h0DDC;
    begin
      int tot;
      tot = 0;
      for (int c = 0; c < N_CH; c++) tot += na[c];
      expw[n_exp++] = tot;
    end
    expw[n_exp++] = 16'h4000;
    for (int c = 0; c < N_CH; c++)
      for (int k = 0; k < na[c]; k++) begin
        expw[n_exp++] = acc[c][k];
        expw[n_exp++] = c;
      end
    expw[n_exp++] = evt_exp & 16'h3FFF;
    expw[n_exp++] = 16'hC000;
    expw[n_exp++] = 16'hFDDC;

    base = cap_n;
    e0 = 0;
    for (int j = -1; j <= DLY + WID + 3; j++) begin
      @(negedge clk);
      if (j == 0) e0 = cyc;
      r = j - DLY;
      trig_v = (j == -1);
      hv = '0;
      for (int i = 0; i < NROW; i++) begin
        if (ROWS[i][0] == ev && r >= ROWS[i][2] && r < ROWS[i][2] + ROWS[i][3]) begin
          if (ROWS[i][1] == TRIG_CH) trig_v = 1'b1;
          else hv[ROWS[i][1]] = 1'b1;
        end
      end
      trig = trig_v;
      hit  = hv;
    end
    trig = 1'b0;
    hit  = '0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (cap_n > base && !ov) break;
    end

    req = EV_REQ[ev];
    len = cap_n - base;
    check_eq(req, $sformatf("ev%0d packet length", ev), len, n_exp);
    if (len > 0) begin
      check_eq("R11", $sformatf("ev%0d start cycle after trigger", ev), capcyc[base] - e0, DLY + WID);
      check_eq("R2", $sformatf("ev%0d contiguous halves", ev), capcyc[cap_n-1] - capcyc[base], len - 1);
    end
    for (int i = 0; i < n_exp && i < len; i++) begin
      string wr;
      if (i == 0 || i == n_exp - 1) wr = "R2";
      else if (i <= 2) wr = "R3";
      else if (i >= n_exp - 3) wr = "R9";
      else if ((i - 3) % 2 == 0) wr = "R4";
      else wr = "R8";
      check_eq(wr, $sformatf("ev%0d half %0d (%s)", ev, i, req), cap[base+i], expw[i]);
    end
    evt_exp++;
    // R10: no second packet from triggers taken while busy
    base = cap_n;
    repeat (DLY + WID + 12) @(negedge clk);
    check_eq("R10", $sformatf("ev%0d no extra packet", ev), cap_n - base, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0;
    trig  = 1'b0;
    hit   = '0;
    repeat (5) @(negedge clk);
    check_eq("R1", "valid during reset", int'(ov), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "valid after reset release", int'(ov), 0);

    for (int e = 0; e < NEV; e++) run_event(e);

    // R1: reset in the middle of an event drops it and restarts numbering
    base = cap_n;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (DLY + 10) @(negedge clk);
    hit[3] = 1'b1;
    @(negedge clk);
    hit[3] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (DLY + WID + 20) @(negedge clk);
    check_eq("R1", "no packet from event cut by reset", cap_n - base, 0);
    evt_exp = 0;
    run_event(1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule